// File: doc/BRIEF.md
# Standby Power-Down Sequencer

This block sequences a processor subsystem between normal running, a light sleep and a deep standby. A CPU-side register write port loads a standby-control register and a timer-start register. A one-cycle sleep request, which the sleep instruction produces, then starts a power-down. The stored standby-enable bit decides which power-down is taken. Light sleep stops only the CPU clock. Standby stops the CPU clock, the supporting-module clocks and the external clock output, and it clears the timer-start register.

Standby is left through an interrupt or through reset. Any wake line (non-maskable, the external request lines, or an on-chip module) starts a settling counter. This counter loads a preset value and counts up at one of eight power-of-two divisions of the input clock. The clocks come back only when the counter overflows. Two status pins report the power state. The oscillator, the interrupt priority logic and the CPU core lie outside the block. The wake lines and the settling setup arrive as plain inputs.

Top module: `pwrdn_seq`

## Requirements
- R1: After reset the block is in run: all three clock enables are 1, status {pin1,pin0} = 2'b00, the control register and the timer-start register read 0.
- R2: A sleep request in run, while control bit 7 (standby enable) is 1, gives standby from the next cycle: the CPU, module and clock-output enables are all 0 and status = 2'b01.
- R3: A sleep request in run, while control bit 7 is 0, gives light sleep from the next cycle: only the CPU enable drops to 0 and status = 2'b10.
- R4: Entering standby clears the timer-start register to 0, even if that register is written in the same cycle. The control register keeps its value.
- R5: In light sleep, any asserted wake line returns the block to run in the next cycle.
- R6: In standby, any asserted wake line (non-maskable, any external line, module) starts settling. Through settling, all clock enables stay 0 and status stays 2'b01.
- R7: Settling lasts (2^CNT_W − preset) × 2^cks cycles, where cks is the 3-bit clock select. Both values are captured on the waking cycle. The block is then in run.
- R8: Wake lines have no effect in run or during settling. A sleep request has no effect outside run.
- R9: Writes to the control and timer-start registers take effect only in run. Outside run they are ignored.
- R10: A sleep request uses the standby-enable bit held before the cycle. A control write in the same cycle affects only later requests.
- R11: Reset asserted during standby or settling forces run at once, without waiting for a clock edge. The status reads 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | CTRL_W | Control register write data (bit STBY_BIT = standby enable) |
| tmr_we_i | input | 1 | Timer-start register write strobe |
| tmr_wdata_i | input | TMR_W | Timer-start register write data |
| sleep_req_i | input | 1 | One-cycle sleep request from the CPU |
| wake_nmi_i | input | 1 | Non-maskable interrupt wake line |
| wake_ext_i | input | EXT_W | External interrupt request wake lines |
| wake_mod_i | input | 1 | On-chip module interrupt wake line |
| wdt_preset_i | input | CNT_W | Settling counter start value |
| wdt_cks_i | input | CKS_W | Settling clock select (division 2^value) |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| mod_clk_en_o | output | 1 | Supporting-module clock enable |
| ck_out_en_o | output | 1 | External clock output enable |
| stat_o | output | 2 | Status pins {pin1, pin0} |
| ctrl_o | output | CTRL_W | Control register contents |
| tmr_start_o | output | TMR_W | Timer-start register contents |

## Verification
The main function is tried with sleep requests under both values of the standby-enable bit. Some requests share their cycle with a control write, which separates the held bit from the newly written bit. Standby is woken once from each class of wake line, and each time the block must go to settling and not straight to run. Settling runs with several preset and clock-select pairs, including the shortest settling and the slowest division. These runs show whether the counter uses both values and whether it captures them at wake. Resets during standby and during settling, and stray strobes in every state, show which inputs each state ignores.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;
   typedef enum logic [1:0] {
      PS_RUN    = 2'd0,
      PS_SLEEP  = 2'd1,
      PS_STBY   = 2'd2,
      PS_SETTLE = 2'd3
   } pstate_e;

   // status pin encodings, index 1 = pin1, index 0 = pin0
   localparam logic [1:0] STAT_RUN   = 2'b00;
   localparam logic [1:0] STAT_SLEEP = 2'b10;
   localparam logic [1:0] STAT_STBY  = 2'b01;
endpackage

// File: rtl/pwrdn_regs.sv
module pwrdn_regs #(
   parameter int CTRL_W = 8,
   parameter int TMR_W  = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_ok_i,
   input  logic              cfg_we_i,
   input  logic [CTRL_W-1:0] cfg_wdata_i,
   input  logic              tmr_we_i,
   input  logic [TMR_W-1:0]  tmr_wdata_i,
   input  logic              tmr_clr_i,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [TMR_W-1:0]  tmr_o
);
   logic [CTRL_W-1:0] ctrl_q;
   logic [TMR_W-1:0]  tmr_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q <= '0;
         tmr_q  <= '0;
      end else begin
         if (wr_ok_i && cfg_we_i) ctrl_q <= cfg_wdata_i;
         if (tmr_clr_i)                   tmr_q <= '0;
         else if (wr_ok_i && tmr_we_i)    tmr_q <= tmr_wdata_i;
      end
   end

   assign ctrl_o = ctrl_q;
   assign tmr_o  = tmr_q;
endmodule

// File: rtl/pwrdn_settle.sv
module pwrdn_settle #(
   parameter int CNT_W = 8,
   parameter int CKS_W = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic             run_i,
   input  logic [CNT_W-1:0] preset_i,
   input  logic [CKS_W-1:0] cks_i,
   output logic             ovf_o
);
   localparam int PRE_W = (1 << CKS_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [PRE_W-1:0] pre_q;
   logic [CKS_W-1:0] cks_q;
   logic [PRE_W-1:0] mask;
   logic             tick;

   for (genvar i = 0; i < PRE_W; i++) begin : g_mask
      assign mask[i] = (32'(cks_q) > i);
   end

   assign tick  = run_i && ((pre_q & mask) == mask);
   assign ovf_o = tick && (cnt_q == {CNT_W{1'b1}});

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
         pre_q <= '0;
         cks_q <= '0;
      end else if (load_i) begin
         cnt_q <= preset_i;
         pre_q <= '0;
         cks_q <= cks_i;
      end else if (run_i) begin
         pre_q <= pre_q + PRE_W'(1);
         if (tick) cnt_q <= cnt_q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/pwrdn_fsm.sv
module pwrdn_fsm
   import pwrdn_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       sleep_req_i,
   input  logic       stby_bit_i,
   input  logic       wake_any_i,
   input  logic       settle_done_i,
   output logic       in_run_o,
   output logic       enter_stby_o,
   output logic       start_settle_o,
   output logic       settling_o,
   output logic       cpu_en_o,
   output logic       mod_en_o,
   output logic       cko_en_o,
   output logic [1:0] stat_o
);
   pstate_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         PS_RUN:    if (sleep_req_i) st_d = stby_bit_i ? PS_STBY : PS_SLEEP;
         PS_SLEEP:  if (wake_any_i) st_d = PS_RUN;
         PS_STBY:   if (wake_any_i) st_d = PS_SETTLE;
         PS_SETTLE: if (settle_done_i) st_d = PS_RUN;
         default:   st_d = PS_RUN;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q <= PS_RUN;
      else         st_q <= st_d;
   end

   assign in_run_o       = (st_q == PS_RUN);
   assign enter_stby_o   = in_run_o && sleep_req_i && stby_bit_i;
   assign start_settle_o = (st_q == PS_STBY) && wake_any_i;
   assign settling_o     = (st_q == PS_SETTLE);

   always_comb begin
      unique case (st_q)
         PS_RUN:   begin cpu_en_o = 1'b1; mod_en_o = 1'b1; cko_en_o = 1'b1; stat_o = STAT_RUN;   end
         PS_SLEEP: begin cpu_en_o = 1'b0; mod_en_o = 1'b1; cko_en_o = 1'b1; stat_o = STAT_SLEEP; end
         default:  begin cpu_en_o = 1'b0; mod_en_o = 1'b0; cko_en_o = 1'b0; stat_o = STAT_STBY;  end
      endcase
   end
endmodule

// File: rtl/pwrdn_seq.sv
module pwrdn_seq #(
   parameter int CTRL_W   = 8,
   parameter int STBY_BIT = 7,
   parameter int TMR_W    = 3,
   parameter int EXT_W    = 4,
   parameter int CNT_W    = 8,
   parameter int CKS_W    = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cfg_we_i,
   input  logic [CTRL_W-1:0] cfg_wdata_i,
   input  logic              tmr_we_i,
   input  logic [TMR_W-1:0]  tmr_wdata_i,
   input  logic              sleep_req_i,
   input  logic              wake_nmi_i,
   input  logic [EXT_W-1:0]  wake_ext_i,
   input  logic              wake_mod_i,
   input  logic [CNT_W-1:0]  wdt_preset_i,
   input  logic [CKS_W-1:0]  wdt_cks_i,
   output logic              cpu_clk_en_o,
   output logic              mod_clk_en_o,
   output logic              ck_out_en_o,
   output logic [1:0]        stat_o,
   output logic [CTRL_W-1:0] ctrl_o,
   output logic [TMR_W-1:0]  tmr_start_o
);
   if (STBY_BIT < 0 || STBY_BIT >= CTRL_W) begin : g_bad_bit
      $error("pwrdn_seq: STBY_BIT outside control register");
   end
   if (CKS_W < 1 || CKS_W > 5) begin : g_bad_cks
      $error("pwrdn_seq: CKS_W must be 1..5");
   end
   if (CNT_W < 2 || TMR_W < 1 || EXT_W < 1) begin : g_bad_w
      $error("pwrdn_seq: width parameter too small");
   end

   logic wake_any, in_run, enter_stby, start_settle, settling, settle_done;

   assign wake_any = wake_nmi_i | (|wake_ext_i) | wake_mod_i;

   pwrdn_regs #(.CTRL_W(CTRL_W), .TMR_W(TMR_W)) u_regs (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_ok_i     (in_run),
      .cfg_we_i    (cfg_we_i),
      .cfg_wdata_i (cfg_wdata_i),
      .tmr_we_i    (tmr_we_i),
      .tmr_wdata_i (tmr_wdata_i),
      .tmr_clr_i   (enter_stby),
      .ctrl_o      (ctrl_o),
      .tmr_o       (tmr_start_o)
   );

   pwrdn_fsm u_fsm (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .sleep_req_i    (sleep_req_i),
      .stby_bit_i     (ctrl_o[STBY_BIT]),
      .wake_any_i     (wake_any),
      .settle_done_i  (settle_done),
      .in_run_o       (in_run),
      .enter_stby_o   (enter_stby),
      .start_settle_o (start_settle),
      .settling_o     (settling),
      .cpu_en_o       (cpu_clk_en_o),
      .mod_en_o       (mod_clk_en_o),
      .cko_en_o       (ck_out_en_o),
      .stat_o         (stat_o)
   );

   pwrdn_settle #(.CNT_W(CNT_W), .CKS_W(CKS_W)) u_settle (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (start_settle),
      .run_i    (settling),
      .preset_i (wdt_preset_i),
      .cks_i    (wdt_cks_i),
      .ovf_o    (settle_done)
   );
endmodule

// File: rtl/pwrdn_seq_chk.sv
module pwrdn_seq_chk #(
   parameter int CTRL_W   = 8,
   parameter int STBY_BIT = 7,
   parameter int TMR_W    = 3,
   parameter int EXT_W    = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              sleep_req_i,
   input logic              wake_nmi_i,
   input logic [EXT_W-1:0]  wake_ext_i,
   input logic              wake_mod_i,
   input logic              cpu_clk_en_o,
   input logic              mod_clk_en_o,
   input logic              ck_out_en_o,
   input logic [1:0]        stat_o,
   input logic [CTRL_W-1:0] ctrl_o,
   input logic [TMR_W-1:0]  tmr_start_o
);
   logic woke;
   assign woke = wake_nmi_i | (|wake_ext_i) | wake_mod_i;

   a_r2_enter_stby: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o == 2'b00 && sleep_req_i && ctrl_o[STBY_BIT]) |=> (stat_o == 2'b01 && !ck_out_en_o));

   a_r3_enter_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o == 2'b00 && sleep_req_i && !ctrl_o[STBY_BIT]) |=> (stat_o == 2'b10 && mod_clk_en_o && !cpu_clk_en_o));

   a_r4_tmr_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o == 2'b00 && sleep_req_i && ctrl_o[STBY_BIT]) |=> (tmr_start_o == '0));

   a_r5_sleep_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o == 2'b10 && woke) |=> (stat_o == 2'b00));

   a_r6_stby_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o == 2'b01) |-> (!cpu_clk_en_o && !mod_clk_en_o && !ck_out_en_o));

   a_r8_run_wake_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o == 2'b00 && woke && !sleep_req_i) |=> (stat_o == 2'b00));

   a_r9_regs_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o != 2'b00) |=> ($stable(ctrl_o) && $stable(tmr_start_o)));
endmodule

bind pwrdn_seq pwrdn_seq_chk #(
   .CTRL_W(CTRL_W), .STBY_BIT(STBY_BIT), .TMR_W(TMR_W), .EXT_W(EXT_W)
) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .sleep_req_i  (sleep_req_i),
   .wake_nmi_i   (wake_nmi_i),
   .wake_ext_i   (wake_ext_i),
   .wake_mod_i   (wake_mod_i),
   .cpu_clk_en_o (cpu_clk_en_o),
   .mod_clk_en_o (mod_clk_en_o),
   .ck_out_en_o  (ck_out_en_o),
   .stat_o       (stat_o),
   .ctrl_o       (ctrl_o),
   .tmr_start_o  (tmr_start_o)
);

// File: tb/pwrdn_seq_tb.sv
module pwrdn_seq_tb_top;
   localparam int PERIOD = 10;

   logic       clk_i = 1'b0;
   logic       rst_ni = 1'b0;
   logic       cfg_we_i = 1'b0;
   logic [7:0] cfg_wdata_i = '0;
   logic       tmr_we_i = 1'b0;
   logic [2:0] tmr_wdata_i = '0;
   logic       sleep_req_i = 1'b0;
   logic       wake_nmi_i = 1'b0;
   logic [3:0] wake_ext_i = '0;
   logic       wake_mod_i = 1'b0;
   logic [7:0] wdt_preset_i = '0;
   logic [2:0] wdt_cks_i = '0;
   logic       cpu_clk_en_o, mod_clk_en_o, ck_out_en_o;
   logic [1:0] stat_o;
   logic [7:0] ctrl_o;
   logic [2:0] tmr_start_o;

   pwrdn_seq dut_i (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
      .tmr_we_i(tmr_we_i), .tmr_wdata_i(tmr_wdata_i),
      .sleep_req_i(sleep_req_i),
      .wake_nmi_i(wake_nmi_i), .wake_ext_i(wake_ext_i), .wake_mod_i(wake_mod_i),
      .wdt_preset_i(wdt_preset_i), .wdt_cks_i(wdt_cks_i),
      .cpu_clk_en_o(cpu_clk_en_o), .mod_clk_en_o(mod_clk_en_o), .ck_out_en_o(ck_out_en_o),
      .stat_o(stat_o), .ctrl_o(ctrl_o), .tmr_start_o(tmr_start_o)
   );

   always #(PERIOD/2) clk_i = ~clk_i;

   // behavioural model: 0 run, 1 sleep, 2 standby, 3 settling
   int         ms;
   logic [7:0] mctrl;
   logic [2:0] mtstr;
   int         remain;
   int         checks = 0;
   int         fails = 0;
   string      req = "R1";
   bit         finished = 0;

   task automatic chk(input string what, input int got, input int exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, got, exp, $time);
      end
   endtask

   task automatic compare_all();
      int e_cpu, e_mod, e_cko, e_st;
      case (ms)
         0:       begin e_cpu = 1; e_mod = 1; e_cko = 1; e_st = 0; end
         1:       begin e_cpu = 0; e_mod = 1; e_cko = 1; e_st = 2; end
         default: begin e_cpu = 0; e_mod = 0; e_cko = 0; e_st = 1; end
      endcase
      chk("cpu_clk_en", int'(cpu_clk_en_o), e_cpu);
      chk("mod_clk_en", int'(mod_clk_en_o), e_mod);
      chk("ck_out_en", int'(ck_out_en_o), e_cko);
      chk("stat", int'(stat_o), e_st);
      chk("ctrl", int'(ctrl_o), int'(mctrl));
      chk("tmr_start", int'(tmr_start_o), int'(mtstr));
   endtask

   task automatic model_reset();
      ms = 0; mctrl = '0; mtstr = '0; remain = 0;
   endtask

   task automatic model_step();
      bit wake;
      wake = wake_nmi_i || (wake_ext_i != 0) || wake_mod_i;
      if (!rst_ni) begin
         model_reset();
         return;
      end
      case (ms)
         0: begin
            bit to_stby;
            to_stby = sleep_req_i && mctrl[7];
            if (sleep_req_i) ms = mctrl[7] ? 2 : 1;
            if (cfg_we_i) mctrl = cfg_wdata_i;
            if (to_stby) mtstr = '0;
            else if (tmr_we_i) mtstr = tmr_wdata_i;
         end
         1: if (wake) ms = 0;
         2: if (wake) begin
               remain = (256 - int'(wdt_preset_i)) * (1 << wdt_cks_i);
               ms = 3;
            end
         default: begin
            remain--;
            if (remain == 0) ms = 0;
         end
      endcase
   endtask

   task automatic step();
      @(posedge clk_i);
      #1;
      model_step();
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step();
   endtask

   task automatic pulse_sleep();
      sleep_req_i = 1'b1; step(); sleep_req_i = 1'b0;
   endtask

   task automatic write_regs(input logic [7:0] c, input logic [2:0] t);
      cfg_we_i = 1'b1; cfg_wdata_i = c; tmr_we_i = 1'b1; tmr_wdata_i = t;
      step();
      cfg_we_i = 1'b0; tmr_we_i = 1'b0;
   endtask

   task automatic settle_run(input logic [7:0] pre, input logic [2:0] cks, input int wsel);
      wdt_preset_i = pre; wdt_cks_i = cks;
      req = "R2"; pulse_sleep();
      req = "R6"; idle(3);
      case (wsel)
         0: wake_nmi_i = 1'b1;
         1: wake_ext_i = 4'b0100;
         default: wake_mod_i = 1'b1;
      endcase
      step();
      wake_nmi_i = 1'b0; wake_ext_i = '0; wake_mod_i = 1'b0;
      // change setup after wake: must not alter the running settle (R7)
      wdt_preset_i = 8'h00; wdt_cks_i = 3'd7;
      req = "R7";
      while (ms == 3) step();
      idle(2);
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: actual hung expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      model_reset();
      #(PERIOD * 2 + 3);
      req = "R1";
      compare_all();
      rst_ni = 1'b1;
      idle(3);

      // light sleep path, R3 and R5
      write_regs(8'h05, 3'b101);
      req = "R3"; pulse_sleep(); idle(2);
      req = "R9"; write_regs(8'h80, 3'b010);
      req = "R8"; pulse_sleep(); idle(1);
      req = "R5"; wake_ext_i = 4'b0010; step(); wake_ext_i = '0; idle(2);

      // wake lines in run do nothing, R8
      req = "R8";
      wake_nmi_i = 1'b1; wake_mod_i = 1'b1; step(); wake_nmi_i = 1'b0; wake_mod_i = 1'b0; idle(1);

      // R10: same-cycle write does not decide this request
      req = "R10";
      cfg_we_i = 1'b1; cfg_wdata_i = 8'h81; sleep_req_i = 1'b1; step();
      cfg_we_i = 1'b0; sleep_req_i = 1'b0; idle(1);
      req = "R5"; wake_mod_i = 1'b1; step(); wake_mod_i = 1'b0; idle(1);

      // R2, R4: standby with tmr written in the same cycle
      req = "R4";
      write_regs(8'h81, 3'b111);
      tmr_we_i = 1'b1; tmr_wdata_i = 3'b011; sleep_req_i = 1'b1; step();
      tmr_we_i = 1'b0; sleep_req_i = 1'b0;
      req = "R9"; write_regs(8'h00, 3'b110);
      req = "R8"; pulse_sleep();
      req = "R6"; wdt_preset_i = 8'hF0; wdt_cks_i = 3'd2;
      wake_nmi_i = 1'b1; step(); wake_nmi_i = 1'b0;
      req = "R8"; wake_ext_i = 4'b1000; step(); wake_ext_i = '0;
      req = "R7"; while (ms == 3) step();
      idle(2);

      // settle timing across setups
      settle_run(8'hFE, 3'd0, 1);
      settle_run(8'hFF, 3'd3, 2);
      settle_run(8'h00, 3'd7, 0);
      settle_run(8'h80, 3'd1, 1);

      // R11: reset during standby and during settling
      req = "R2"; pulse_sleep(); idle(2);
      req = "R11"; rst_ni = 1'b0; #2; model_reset(); compare_all();
      step(); rst_ni = 1'b1; idle(2);
      write_regs(8'h80, 3'b001);
      wdt_preset_i = 8'h10; wdt_cks_i = 3'd4;
      pulse_sleep(); wake_mod_i = 1'b1; step(); wake_mod_i = 1'b0; idle(20);
      req = "R11"; rst_ni = 1'b0; #2; model_reset(); compare_all();
      step(); rst_ni = 1'b1; idle(3);

      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule